// File: doc/BRIEF.md
# Extended-Dividend Saturating Integer Divider

This block divides integers in four modes for a 64-bit datapath: 32-bit unsigned, 32-bit signed, 64-bit unsigned and 64-bit signed. In the 32-bit modes the dividend is 64 bits wide. Its upper half comes from a 32-bit Y register and its lower half from the low word of the first operand. A 32-bit quotient that does not fit in 32 bits is clamped to the limit of the right sign and does not wrap. The 64-bit modes divide the first operand by the divisor directly and do not clamp.

The divisor is either the second register operand or a sign-extended 13-bit immediate. Each division runs as a radix-2 restoring loop with one quotient bit per clock. Signed modes divide magnitudes and fix the sign afterwards. A start pulse begins an operation, busy covers its run, and a one-cycle done pulse carries the result, a divide-by-zero fault and, when asked for, condition flags for a 32-bit and a 64-bit view of the result.

Top module: `xdiv_unit`

## Requirements
- R1: `op_mode` selects the operation: 2'b00 32-bit unsigned, 2'b01 32-bit signed, 2'b10 64-bit unsigned, 2'b11 64-bit signed; signed quotients truncate toward zero.
- R2: A zero divisor gives a done pulse one cycle after the start is accepted, with `div_zero` high, `result` unchanged from its previous value and `cc_valid` low.
- R3: In the 32-bit modes the dividend is {y_in[31:0], rs1[31:0]}. The 64-bit modes use all of rs1 as the dividend and ignore y_in.
- R4: A 32-bit unsigned quotient with any bit set above bit 31 returns 64'h00000000_FFFFFFFF.
- R5: A 32-bit signed quotient above +2^31-1 returns 64'h00000000_7FFFFFFF. This includes dividend -2^31 with divisor -1.
- R6: A 32-bit signed quotient below -2^31 returns 64'hFFFFFFFF_80000000. A quotient of exactly -2^31 is returned as is, without clamping.
- R7: An in-range 32-bit signed quotient is returned sign-extended to 64 bits. In 32-bit modes the divisor is the low 32 bits of the selected operand, sign-extended when signed and zero-extended when unsigned.
- R8: The 64-bit modes never clamp. A signed 64-bit divide of -2^63 by -1 returns 64'h80000000_00000000.
- R9: With `use_imm` high the divisor is `imm` sign-extended to 64 bits, and `rs2` has no effect.
- R10: A start is accepted only while `busy` is low. `busy` is high from the cycle after an accepted non-zero-divisor start until done, and a start while busy has no effect.
- R11: `done` lasts exactly one cycle, and `result`, `div_zero`, `cc_out` and `cc_valid` are valid with it.
- R12: `cc_out[3:0]` holds the N, Z, V, C flags of result[31:0] and `cc_out[7:4]` holds N, Z, V, C of the full 64-bit result. V in the low nibble is set only when a 32-bit quotient was clamped. The other V and both C flags are 0. `cc_valid` is high with done only when `set_flags` was high at start and no fault occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (taken only when not busy) |
| op_mode | input | 2 | Operation select, see R1 |
| set_flags | input | 1 | Request condition-flag output |
| use_imm | input | 1 | Take the divisor from `imm` instead of `rs2` |
| rs1 | input | 64 | First operand (dividend source) |
| rs2 | input | 64 | Second register operand (divisor source) |
| imm | input | 13 | Signed immediate divisor |
| y_in | input | 32 | Y register, upper dividend word in 32-bit modes |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient, possibly clamped |
| div_zero | output | 1 | Divide-by-zero fault, valid with done |
| cc_out | output | 8 | {64-bit NZVC, 32-bit NZVC} flags |
| cc_valid | output | 1 | Flags valid, with done |

## Verification
The bench builds the block with its default width of 64 bits, so the Y register and the result views are 32 bits wide. With 32-bit views, the exact clamp boundaries can be driven with short constants: 2^31, -2^31 and -2^32 as dividends, and -2^31 divided by -1. The 64-bit -2^63 by -1 case is also reachable at this width. It exercises the magnitude path, where a wrapped quotient would otherwise look negative. Directed cases also cover the immediate divisor, a start while busy and a zero divisor after a previous result.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
  typedef enum logic [1:0] {
    DM_U32 = 2'b00,
    DM_S32 = 2'b01,
    DM_U64 = 2'b10,
    DM_S64 = 2'b11
  } div_mode_e;
endpackage

// File: rtl/xdiv_prep.sv
module xdiv_prep
  import xdiv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 13
) (
  input  div_mode_e        mode,
  input  logic             use_imm,
  input  logic [XLEN-1:0]  rs1,
  input  logic [XLEN-1:0]  rs2,
  input  logic [IMMW-1:0]  imm,
  input  logic [XLEN/2-1:0] y_in,
  output logic [XLEN-1:0]  dvd_mag,
  output logic [XLEN-1:0]  dvs_mag,
  output logic             q_neg,
  output logic             dvs_zero
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] opb, dvd_raw, dvs_raw;
  logic            is_signed, wide, dvd_neg, dvs_neg;

  always_comb begin
    is_signed = mode[0];
    wide      = mode[1];
    opb = use_imm ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : rs2;
    if (wide) begin
      dvd_raw = rs1;
      dvs_raw = opb;
    end else begin
      dvd_raw = {y_in, rs1[HALF-1:0]};
      dvs_raw = is_signed ? {{HALF{opb[HALF-1]}}, opb[HALF-1:0]}
                          : {{HALF{1'b0}}, opb[HALF-1:0]};
    end
    dvd_neg  = is_signed & dvd_raw[XLEN-1];
    dvs_neg  = is_signed & dvs_raw[XLEN-1];
    dvd_mag  = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
    dvs_mag  = dvs_neg ? (~dvs_raw + 1'b1) : dvs_raw;
    q_neg    = dvd_neg ^ dvs_neg;
    dvs_zero = (dvs_raw == '0);
  end
endmodule

// File: rtl/xdiv_core.sv
module xdiv_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, dvs_q;
  logic [CW-1:0] cnt;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem_q <= '0;
        quo   <= dvd;
        dvs_q <= dvs;
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo   <= {quo[W-2:0], fits};
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R10: one quotient bit per cycle while running
  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    busy && !load |=> cnt == $past(cnt) - 1'b1);

  // R11: completion never overlaps a running loop
  p_fin_idle_r11: assert property (@(posedge clk) disable iff (rst)
    fin |-> !busy);
endmodule

// File: rtl/xdiv_post.sv
module xdiv_post
  import xdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  div_mode_e       mode,
  input  logic            q_neg,
  input  logic [XLEN-1:0] quo_mag,
  output logic [XLEN-1:0] res,
  output logic [3:0]      cc_half,
  output logic [3:0]      cc_full
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] POS_LIM   = {{(XLEN-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [XLEN-1:0] NEG_MAG   = {{(XLEN-HALF){1'b0}}, 1'b1, {(HALF-1){1'b0}}};
  localparam logic [XLEN-1:0] NEG_CLAMP = {{(XLEN-HALF+1){1'b1}}, {(HALF-1){1'b0}}};
  localparam logic [XLEN-1:0] U_CLAMP   = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

  logic [XLEN-1:0] q_signed;
  logic            clamped;

  always_comb begin
    q_signed = q_neg ? (~quo_mag + 1'b1) : quo_mag;
    clamped  = 1'b0;
    res      = quo_mag;
    unique case (mode)
      DM_U32: begin
        if (|quo_mag[XLEN-1:HALF]) begin
          res     = U_CLAMP;
          clamped = 1'b1;
        end
      end
      DM_S32: begin
        if (!q_neg && quo_mag > POS_LIM) begin
          res     = POS_LIM;
          clamped = 1'b1;
        end else if (q_neg && quo_mag > NEG_MAG) begin
          res     = NEG_CLAMP;
          clamped = 1'b1;
        end else begin
          res = q_signed;
        end
      end
      DM_U64: res = quo_mag;
      DM_S64: res = q_signed;
      default: res = quo_mag;
    endcase
    cc_half = {res[HALF-1], (res[HALF-1:0] == '0), clamped, 1'b0};
    cc_full = {res[XLEN-1], (res == '0), 2'b00};
  end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
  import xdiv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op_mode,
  input  logic              set_flags,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   rs1,
  input  logic [XLEN-1:0]   rs2,
  input  logic [IMMW-1:0]   imm,
  input  logic [XLEN/2-1:0] y_in,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result,
  output logic              div_zero,
  output logic [7:0]        cc_out,
  output logic              cc_valid
);
  localparam int HALF = XLEN / 2;

  div_mode_e       mode_in, mode_q;
  logic            neg_q, flags_q, accept;
  logic [XLEN-1:0] dvd_mag, dvs_mag, quo_mag, post_res;
  logic            q_neg, dvs_zero, core_busy, core_fin;
  logic [3:0]      cc_half, cc_full;

  assign mode_in = div_mode_e'(op_mode);
  assign accept  = start && !busy;

  xdiv_prep #(.XLEN(XLEN), .IMMW(IMMW)) u_prep (
    .mode(mode_in), .use_imm(use_imm), .rs1(rs1), .rs2(rs2), .imm(imm),
    .y_in(y_in), .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .q_neg(q_neg),
    .dvs_zero(dvs_zero)
  );

  xdiv_core #(.W(XLEN)) u_core (
    .clk(clk), .rst(rst), .load(accept && !dvs_zero), .dvd(dvd_mag),
    .dvs(dvs_mag), .busy(core_busy), .fin(core_fin), .quo(quo_mag)
  );

  xdiv_post #(.XLEN(XLEN)) u_post (
    .mode(mode_q), .q_neg(neg_q), .quo_mag(quo_mag), .res(post_res),
    .cc_half(cc_half), .cc_full(cc_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= DM_U32;
      neg_q    <= 1'b0;
      flags_q  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      div_zero <= 1'b0;
      cc_out   <= '0;
      cc_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      cc_valid <= 1'b0;
      if (accept) begin
        mode_q  <= mode_in;
        neg_q   <= q_neg;
        flags_q <= set_flags;
        if (dvs_zero) begin
          done     <= 1'b1;
          div_zero <= 1'b1;
        end else begin
          busy <= 1'b1;
        end
      end
      if (core_fin) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        result   <= post_res;
        cc_out   <= {cc_full, cc_half};
        cc_valid <= flags_q;
      end
    end
  end

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: a fault leaves the destination untouched and raises no flags
  p_zero_hold_r2: assert property (@(posedge clk) disable iff (rst)
    done && div_zero |-> result == $past(result) && !cc_valid);

  // R4: unsigned 32-bit results never exceed 32 bits
  p_u32_fit_r4: assert property (@(posedge clk) disable iff (rst)
    done && !div_zero && mode_q == DM_U32 |-> result[XLEN-1:HALF] == '0);

  // R6: signed 32-bit results are always a sign extension of bit 31
  p_s32_fit_r6: assert property (@(posedge clk) disable iff (rst)
    done && !div_zero && mode_q == DM_S32 |->
      (result[XLEN-1:HALF-1] == '0) || (&result[XLEN-1:HALF-1]));

  // R12: flags only accompany a fault-free completion
  p_ccv_r12: assert property (@(posedge clk) disable iff (rst)
    cc_valid |-> done && !div_zero);

  // R10: leaving busy always coincides with completion
  p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: tb/xdiv_unit_test.sv
module xdiv_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_mode = 2'b00;
  logic        set_flags = 1'b0;
  logic        use_imm = 1'b0;
  logic [63:0] rs1 = '0;
  logic [63:0] rs2 = '0;
  logic [12:0] imm = '0;
  logic [31:0] y_in = '0;
  logic        busy, done, div_zero, cc_valid;
  logic [63:0] result;
  logic [7:0]  cc_out;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xdiv_unit uut (
    .clk(clk), .rst(rst), .start(start), .op_mode(op_mode),
    .set_flags(set_flags), .use_imm(use_imm), .rs1(rs1), .rs2(rs2),
    .imm(imm), .y_in(y_in), .busy(busy), .done(done), .result(result),
    .div_zero(div_zero), .cc_out(cc_out), .cc_valid(cc_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Launch one operation and wait at a falling edge until done is high.
  task automatic run(input logic [1:0] m, input logic sf, input logic ui,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic [12:0] im, input logic [31:0] y);
    @(negedge clk);
    op_mode = m; set_flags = sf; use_imm = ui;
    rs1 = a; rs2 = b; imm = im; y_in = y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R11 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic expect_res(input string req, input logic [63:0] q,
                            input logic [7:0] cc);
    check({req, " result"}, result, q);
    check({req, " fault"}, {63'd0, div_zero}, 64'd0);
    if (set_flags) begin
      check({req, " cc_valid"}, {63'd0, cc_valid}, 64'd1);
      check({req, " flags"}, {56'd0, cc_out}, {56'd0, cc});
    end
    @(negedge clk);
    check("R11 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    check("R11 reset done", {63'd0, done}, 64'd0);
    check("R10 reset busy", {63'd0, busy}, 64'd0);
    check("R11 reset result", result, 64'd0);
  endtask

  task automatic t_u64;
    run(2'b10, 1'b1, 1'b0, 64'd100, 64'd7, 13'd0, 32'd0);
    expect_res("R1 u64", 64'd14, 8'h00);
    run(2'b10, 1'b1, 1'b0, 64'd3, 64'd5, 13'd0, 32'd0);
    expect_res("R12 zero flags", 64'd0, 8'h44);
    run(2'b10, 1'b0, 1'b0, 64'h40, 64'd2, 13'd0, 32'd5);
    expect_res("R3 u64 ignores y", 64'h20, 8'h00);
    check("R12 no flags requested", {63'd0, cc_valid}, 64'd0);
  endtask

  task automatic t_u32;
    run(2'b00, 1'b1, 1'b0, 64'hABCD_0000_0000_0000, 64'h10, 13'd0, 32'd1);
    expect_res("R3 u32 y dividend", 64'h1000_0000, 8'h00);
    run(2'b00, 1'b1, 1'b0, 64'd0, 64'd1, 13'd0, 32'd1);
    expect_res("R4 u32 clamp", 64'h0000_0000_FFFF_FFFF, 8'h0A);
  endtask

  task automatic t_s32;
    run(2'b01, 1'b1, 1'b0, 64'h8000_0000, 64'd1, 13'd0, 32'd0);
    expect_res("R5 s32 pos clamp", 64'h0000_0000_7FFF_FFFF, 8'h02);
    run(2'b01, 1'b1, 1'b0, 64'h8000_0000, 64'hFFFF_FFFF, 13'd0, 32'hFFFF_FFFF);
    expect_res("R5 s32 min by -1", 64'h0000_0000_7FFF_FFFF, 8'h02);
    run(2'b01, 1'b1, 1'b0, 64'h0, 64'd1, 13'd0, 32'hFFFF_FFFF);
    expect_res("R6 s32 neg clamp", 64'hFFFF_FFFF_8000_0000, 8'h8A);
    run(2'b01, 1'b1, 1'b0, 64'h8000_0000, 64'd1, 13'd0, 32'hFFFF_FFFF);
    expect_res("R6 s32 exact min", 64'hFFFF_FFFF_8000_0000, 8'h88);
    run(2'b01, 1'b1, 1'b0, 64'hFFFF_FFF9, 64'd2, 13'd0, 32'hFFFF_FFFF);
    expect_res("R7 s32 trunc", 64'hFFFF_FFFF_FFFF_FFFD, 8'h88);
    run(2'b01, 1'b1, 1'b0, 64'd7, 64'h1234_5678_FFFF_FFFE, 13'd0, 32'd0);
    expect_res("R7 s32 low divisor", 64'hFFFF_FFFF_FFFF_FFFD, 8'h88);
  endtask

  task automatic t_s64;
    run(2'b11, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 13'd0, 32'd0);
    expect_res("R8 s64 no clamp", 64'h8000_0000_0000_0000, 8'h84);
    run(2'b11, 1'b0, 1'b0, -64'sd100, 64'd7, 13'd0, 32'd0);
    expect_res("R1 s64 trunc", 64'hFFFF_FFFF_FFFF_FFF2, 8'h00);
  endtask

  task automatic t_imm;
    run(2'b11, 1'b0, 1'b1, 64'd1000, 64'd3, 13'h1FF8, 32'd0);
    expect_res("R9 imm divisor", 64'hFFFF_FFFF_FFFF_FF83, 8'h00);
  endtask

  task automatic t_zero;
    logic [63:0] prev;
    run(2'b10, 1'b0, 1'b0, 64'd77, 64'd7, 13'd0, 32'd0);
    expect_res("R2 setup", 64'd11, 8'h00);
    prev = result;
    @(negedge clk);
    op_mode = 2'b01; set_flags = 1'b1; use_imm = 1'b0;
    rs1 = 64'd5; rs2 = 64'hFFFF_FFFF_0000_0000; y_in = 32'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 zero done", {63'd0, done}, 64'd1);
    check("R2 zero fault", {63'd0, div_zero}, 64'd1);
    check("R2 zero result held", result, prev);
    check("R2 zero no flags", {63'd0, cc_valid}, 64'd0);
    check("R2 zero not busy", {63'd0, busy}, 64'd0);
    run(2'b10, 1'b0, 1'b1, 64'd5, 64'd1, 13'd0, 32'd0);
    check("R2 imm zero fault", {63'd0, div_zero}, 64'd1);
    check("R9 imm zero result held", result, prev);
  endtask

  task automatic t_busy;
    int dones = 0;
    @(negedge clk);
    op_mode = 2'b10; set_flags = 1'b0; use_imm = 1'b0;
    rs1 = 64'd1000; rs2 = 64'd10; y_in = 32'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", {63'd0, busy}, 64'd1);
    repeat (5) @(negedge clk);
    rs1 = 64'd5; rs2 = 64'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        dones++;
        if (dones == 1) check("R10 start ignored while busy", result, 64'd100);
      end
      @(negedge clk);
    end
    check("R10 single completion", dones, 64'd1);
    check("R10 idle after", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_u64();
    t_u32();
    t_s32();
    t_s64();
    t_imm();
    t_zero();
    t_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule